// File: doc/BRIEF.md
# Variable-Length Bytecode Instruction Decoder

This block turns a stream of 16-bit program words into decoded instruction records. Words come in one per cycle from a fetch stage under a valid/ready handshake. The first word of each instruction fixes its shape. That shape depends only on the format bits: a top nibble of zero moves the opcode down one nibble and turns operand B into a trailing immediate word. A handful of escape ranges hold the special, I/O and branch instructions, and they change how the operands are laid out. The decoder works out how many trailing words the instruction still needs (zero, one or two), takes them in as they arrive, and routes each one to operand A, operand B or the branch target.

Once the last word of an instruction has been taken, the complete record is shown on the outputs. It holds the operation class, the opcode, operands A and B (each a register index or an immediate, with a flag saying which), an optional branch target, a 6-bit port number for I/O, and the instruction length in words. The record stays on the outputs until the consumer accepts it. A new word can be taken in the same cycle that the previous record is accepted. Any unassigned or reserved encoding produces a one-word record with the illegal flag set. The next word is then decoded as the start of a new instruction.

Top module: `wordcode_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: When the top nibble is 2 or higher and the opcode is assigned, the record has opcode = bits 15:8, A = register bits 7:4 and B = register bits 3:0. Length is 1 and class is 4 (ordinary), except for branches (R7, R8).
- R3: When the top nibble is 0 and bits 11:8 are 2 or higher, the record has opcode = bits 11:4 and A = register bits 3:0. B is the next word, with `out_b_imm` = 1. Length is 2, or 3 for a two-source branch.
- R4: The words 0x0000 to 0x0008 are class 0, with opcode equal to the low byte. 0x0000 and 0x0006 to 0x0008 have length 1. 0x0001 to 0x0003 take one word into A (`out_a_imm` = 1). 0x0004 and 0x0005 take two words: the first goes to A and the second to B, both flagged immediate.
- R5: The words 0x0010 to 0x006F are class 0, with opcode = bits 7:4 followed by a zero nibble. For 0x1_, 0x2_, 0x3_ and 0x6_, A = register bits 3:0 and length is 1. For 0x4_ and 0x5_, one word goes to A as an immediate, B = register bits 3:0, and length is 2.
- R6: I/O records are class 1.
  - `0001 00pp aaaa pppp` gives opcode 0x10, A = bits 7:4, and port = {bits 9:8, bits 3:0}.
  - `0001 01pp pppp bbbb` gives opcode 0x14, B = bits 3:0, and port = {bits 9:8, bits 7:4}.
  - `0000 0001 01pp pppp` gives opcode 0x14, port = bits 5:0, and B = the next word as an immediate, with length 2.
- R7: Opcodes 0x20 to 0x2F are class 2 and set `out_has_target`. The target is the last trailing word. In register form the length is 2. In immediate form the length is 3, and B is the first trailing word.
- R8: Opcodes 0x30 to 0x3F are class 3. They take no extra target word, operand B acts as the target, and `out_has_target` = 0.
- R9: The following encodings give `out_illegal` = 1, length 1, and all other record fields zero:
  - 0x0009 to 0x000F;
  - 0x0070 to 0x00FF;
  - 0x0100 to 0x013F;
  - 0x0180 to 0x01FF;
  - `0001 1xxx xxxx xxxx`;
  - any opcode with bit 7 set.

  The following word starts a new instruction.
- R10: These opcodes are illegal in both the register and the immediate form: 0x26–0x27, 0x2E–0x2F, 0x33–0x37, 0x3B–0x3F, 0x5D–0x5F, 0x66–0x67, 0x6E–0x6F and 0x70–0x7F.
- R11: While `out_valid` = 1 and `out_ready` = 0, the record is held unchanged and `in_ready` = 0.
- R12: A record appears in the cycle after its last word is taken. `out_len` equals the number of words consumed. Acceptance of one record and the taking of the next word can happen at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch word is present |
| in_ready | output | 1 | Decoder takes the word this cycle |
| in_word | input | WORD_W | Program word |
| out_valid | output | 1 | Decoded record is present |
| out_ready | input | 1 | Consumer accepts the record |
| out_class | output | 3 | 0 special, 1 I/O, 2 two-source branch, 3 one-source branch, 4 ordinary |
| out_opcode | output | 8 | Opcode |
| out_a | output | WORD_W | Operand A: register index or immediate |
| out_a_imm | output | 1 | Operand A is an immediate |
| out_b | output | WORD_W | Operand B: register index or immediate |
| out_b_imm | output | 1 | Operand B is an immediate |
| out_target | output | WORD_W | Branch target word |
| out_has_target | output | 1 | Target field is meaningful |
| out_port | output | 6 | I/O port number |
| out_len | output | 2 | Instruction length in words (1 to 3) |
| out_illegal | output | 1 | Unassigned or reserved encoding |

## Verification
Two events can fall on the same clock edge: the consumer accepting a held record, and the fetch side delivering the first word of the next instruction. The bench sets up this collision by holding `out_ready` low while a word waits at the input. It checks that `in_ready` stays low and the record stays frozen during the stall. It then raises `out_ready` while the word is still presented. The outcome is judged one cycle later: the old record must be gone, the new record must decode that waiting word, and the bench's length counter must agree with `out_len`. Exhaustive sweeps over the first 8192 words and over every top byte cover field routing, including trailing words that arrive with idle gaps between them.

// File: rtl/wcd_pkg.sv
package wcd_pkg;

  localparam int REG_W  = 4;
  localparam int OPC_W  = 8;
  localparam int PORT_W = 6;
  localparam int LEN_W  = 2;

  typedef enum logic [2:0] {
    CL_SPECIAL = 3'd0,
    CL_IO      = 3'd1,
    CL_BR2     = 3'd2,
    CL_BR1     = 3'd3,
    CL_ORD     = 3'd4
  } cls_e;

  typedef enum logic [1:0] {
    SL_A = 2'd0,
    SL_B = 2'd1,
    SL_T = 2'd2
  } slot_e;

  typedef struct packed {
    cls_e              cls;
    logic [OPC_W-1:0]  opcode;
    logic              a_imm;
    logic              b_imm;
    logic              has_target;
    logic              illegal;
    logic [PORT_W-1:0] port;
    logic [LEN_W-1:0]  len;
  } hdr_t;

  // Assigned ordinary opcodes (0x20..0x6F region), by group nibble.
  function automatic logic opcode_assigned(input logic [OPC_W-1:0] op);
    logic ok;
    ok = 1'b0;
    if (!op[7]) begin
      case (op[6:4])
        3'd2: ok = (op[2:1] != 2'b11);
        3'd3: ok = (op[1:0] != 2'b11) && !op[2];
        3'd4: ok = 1'b1;
        3'd5: ok = (op[3:0] <= 4'hC);
        3'd6: ok = (op[2:1] != 2'b11);
        default: ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

  function automatic cls_e class_of(input logic [OPC_W-1:0] op);
    if (op[7:4] == 4'h2)      return CL_BR2;
    else if (op[7:4] == 4'h3) return CL_BR1;
    else                      return CL_ORD;
  endfunction

endpackage

// File: rtl/wcd_classify.sv
module wcd_classify
  import wcd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] word,
  output hdr_t              hdr,
  output logic [REG_W-1:0]  a_reg,
  output logic [REG_W-1:0]  b_reg,
  output logic [1:0]        need,
  output slot_e             dst0,
  output slot_e             dst1
);

  logic        upper_nz;
  logic [15:0] w;
  logic        ill;

  generate
    if (WORD_W > 16) begin : g_wide
      assign upper_nz = |word[WORD_W-1:16];
    end else begin : g_narrow
      assign upper_nz = 1'b0;
    end
  endgenerate

  assign w = word[15:0];

  always_comb begin
    hdr   = '0;
    a_reg = '0;
    b_reg = '0;
    need  = 2'd0;
    dst0  = SL_A;
    dst1  = SL_B;
    ill   = 1'b0;
    if (upper_nz) begin
      ill = 1'b1;
    end else if (w[15:12] == 4'h1) begin
      hdr.cls = CL_IO;
      if (w[11]) begin
        ill = 1'b1;
      end else if (!w[10]) begin
        hdr.opcode = 8'h10;
        a_reg      = w[7:4];
        hdr.port   = {w[9:8], w[3:0]};
      end else begin
        hdr.opcode = 8'h14;
        b_reg      = w[3:0];
        hdr.port   = {w[9:8], w[7:4]};
      end
    end else if (w[15:12] != 4'h0) begin
      if (!opcode_assigned(w[15:8])) begin
        ill = 1'b1;
      end else begin
        hdr.opcode = w[15:8];
        hdr.cls    = class_of(w[15:8]);
        a_reg      = w[7:4];
        b_reg      = w[3:0];
        if (hdr.cls == CL_BR2) begin
          need           = 2'd1;
          dst0           = SL_T;
          hdr.has_target = 1'b1;
        end
      end
    end else if (w[11:8] >= 4'h2) begin
      if (!opcode_assigned(w[11:4])) begin
        ill = 1'b1;
      end else begin
        hdr.opcode = w[11:4];
        hdr.cls    = class_of(w[11:4]);
        hdr.b_imm  = 1'b1;
        a_reg      = w[3:0];
        need       = 2'd1;
        dst0       = SL_B;
        if (hdr.cls == CL_BR2) begin
          need           = 2'd2;
          dst1           = SL_T;
          hdr.has_target = 1'b1;
        end
      end
    end else if (w[11:8] == 4'h1) begin
      if (w[7:6] == 2'b01) begin
        hdr.cls    = CL_IO;
        hdr.opcode = 8'h14;
        hdr.port   = w[5:0];
        hdr.b_imm  = 1'b1;
        need       = 2'd1;
        dst0       = SL_B;
      end else begin
        ill = 1'b1;
      end
    end else if (w[7:4] == 4'h0) begin
      hdr.opcode = w[7:0];
      case (w[3:0])
        4'h0, 4'h6, 4'h7, 4'h8: need = 2'd0;
        4'h1, 4'h2, 4'h3: begin
          hdr.a_imm = 1'b1;
          need      = 2'd1;
        end
        4'h4, 4'h5: begin
          hdr.a_imm = 1'b1;
          hdr.b_imm = 1'b1;
          need      = 2'd2;
        end
        default: ill = 1'b1;
      endcase
    end else if (w[7:4] <= 4'h6) begin
      hdr.opcode = {w[7:4], 4'h0};
      if (w[7:4] == 4'h4 || w[7:4] == 4'h5) begin
        hdr.a_imm = 1'b1;
        b_reg     = w[3:0];
        need      = 2'd1;
      end else begin
        a_reg = w[3:0];
      end
    end else begin
      ill = 1'b1;
    end

    if (ill) begin
      hdr         = '0;
      hdr.illegal = 1'b1;
      hdr.len     = 2'd1;
      a_reg       = '0;
      b_reg       = '0;
      need        = 2'd0;
      dst0        = SL_A;
      dst1        = SL_B;
    end else begin
      hdr.len = need + 2'd1;
    end
  end

endmodule

// File: rtl/wcd_gather.sv
module wcd_gather
  import wcd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_core_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              out_ready,
  input  hdr_t              c_hdr,
  input  logic [REG_W-1:0]  c_a_reg,
  input  logic [REG_W-1:0]  c_b_reg,
  input  logic [1:0]        c_need,
  input  slot_e             c_dst0,
  input  slot_e             c_dst1,
  output logic              out_valid,
  output hdr_t              rec_hdr,
  output logic [WORD_W-1:0] rec_a,
  output logic [WORD_W-1:0] rec_b,
  output logic [WORD_W-1:0] rec_t
);

  localparam int ZW = WORD_W - REG_W;

  logic              valid_q, valid_n;
  logic              busy_q, busy_n;
  logic [1:0]        left_q, left_n;
  logic              second_q, second_n;
  slot_e             dst0_q, dst0_n, dst1_q, dst1_n;
  hdr_t              hdr_q, hdr_n;
  logic [WORD_W-1:0] a_q, a_n, b_q, b_n, t_q, t_n;
  logic              take;
  slot_e             slot;

  assign in_ready = !valid_q || out_ready;
  assign take     = in_valid && in_ready;
  assign slot     = second_q ? dst1_q : dst0_q;

  always_comb begin
    valid_n  = valid_q;
    busy_n   = busy_q;
    left_n   = left_q;
    second_n = second_q;
    dst0_n   = dst0_q;
    dst1_n   = dst1_q;
    hdr_n    = hdr_q;
    a_n      = a_q;
    b_n      = b_q;
    t_n      = t_q;
    if (valid_q && out_ready) valid_n = 1'b0;
    if (take) begin
      if (!busy_q) begin
        hdr_n = c_hdr;
        a_n   = {{ZW{1'b0}}, c_a_reg};
        b_n   = {{ZW{1'b0}}, c_b_reg};
        t_n   = '0;
        if (c_need == 2'd0) begin
          valid_n = 1'b1;
        end else begin
          busy_n   = 1'b1;
          left_n   = c_need;
          second_n = 1'b0;
          dst0_n   = c_dst0;
          dst1_n   = c_dst1;
        end
      end else begin
        case (slot)
          SL_A:    a_n = in_word;
          SL_B:    b_n = in_word;
          default: t_n = in_word;
        endcase
        left_n   = left_q - 2'd1;
        second_n = 1'b1;
        if (left_q == 2'd1) begin
          busy_n  = 1'b0;
          valid_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_q  <= 1'b0;
      busy_q   <= 1'b0;
      left_q   <= 2'd0;
      second_q <= 1'b0;
      dst0_q   <= SL_A;
      dst1_q   <= SL_B;
    end else begin
      valid_q <= valid_n;
      if (take) begin
        busy_q   <= busy_n;
        left_q   <= left_n;
        second_q <= second_n;
        dst0_q   <= dst0_n;
        dst1_q   <= dst1_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      hdr_q <= hdr_n;
      a_q   <= a_n;
      b_q   <= b_n;
      t_q   <= t_n;
    end
  end

  assign out_valid = valid_q;
  assign rec_hdr   = hdr_q;
  assign rec_a     = a_q;
  assign rec_b     = b_q;
  assign rec_t     = t_q;

endmodule

// File: rtl/wordcode_decoder.sv
module wordcode_decoder
  import wcd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_class,
  output logic [OPC_W-1:0]  out_opcode,
  output logic [WORD_W-1:0] out_a,
  output logic              out_a_imm,
  output logic [WORD_W-1:0] out_b,
  output logic              out_b_imm,
  output logic [WORD_W-1:0] out_target,
  output logic              out_has_target,
  output logic [PORT_W-1:0] out_port,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_illegal
);

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  hdr_t             c_hdr, rec_hdr;
  logic [REG_W-1:0] c_a_reg, c_b_reg;
  logic [1:0]       c_need;
  slot_e            c_dst0, c_dst1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  wcd_classify #(.WORD_W(WORD_W)) u_classify (
    .word  (in_word),
    .hdr   (c_hdr),
    .a_reg (c_a_reg),
    .b_reg (c_b_reg),
    .need  (c_need),
    .dst0  (c_dst0),
    .dst1  (c_dst1)
  );

  wcd_gather #(.WORD_W(WORD_W)) u_gather (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_word    (in_word),
    .out_ready  (out_ready),
    .c_hdr      (c_hdr),
    .c_a_reg    (c_a_reg),
    .c_b_reg    (c_b_reg),
    .c_need     (c_need),
    .c_dst0     (c_dst0),
    .c_dst1     (c_dst1),
    .out_valid  (out_valid),
    .rec_hdr    (rec_hdr),
    .rec_a      (out_a),
    .rec_b      (out_b),
    .rec_t      (out_target)
  );

  assign out_class      = rec_hdr.cls;
  assign out_opcode     = rec_hdr.opcode;
  assign out_a_imm      = rec_hdr.a_imm;
  assign out_b_imm      = rec_hdr.b_imm;
  assign out_has_target = rec_hdr.has_target;
  assign out_port       = rec_hdr.port;
  assign out_len        = rec_hdr.len;
  assign out_illegal    = rec_hdr.illegal;

endmodule

// File: rtl/wcd_checker.sv
module wcd_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [2:0]        out_class,
  input logic [7:0]        out_opcode,
  input logic [WORD_W-1:0] out_a,
  input logic [WORD_W-1:0] out_b,
  input logic              out_b_imm,
  input logic [WORD_W-1:0] out_target,
  input logic              out_has_target,
  input logic [1:0]        out_len,
  input logic              out_illegal
);

  logic       hold_q;
  logic [1:0] cnt_q;
  logic       take;
  logic       fresh;

  assign take  = in_valid && in_ready;
  assign fresh = out_valid && !hold_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      hold_q <= 1'b0;
      cnt_q  <= 2'd0;
    end else begin
      hold_q <= out_valid && !out_ready;
      if (fresh)     cnt_q <= take ? 2'd1 : 2'd0;
      else if (take) cnt_q <= cnt_q + 2'd1;
    end
  end

  p_reset_r1: assert property (@(posedge clk) !rst_core_n |-> !out_valid);

  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_valid && !out_ready |-> !in_ready);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_valid && !out_ready |=> out_valid && $stable(out_opcode) && $stable(out_a)
      && $stable(out_b) && $stable(out_target) && $stable(out_len));

  p_len_count_r12: assert property (@(posedge clk) disable iff (!rst_core_n)
    fresh |-> out_len == cnt_q);

  p_illegal_len_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_valid && out_illegal |-> out_len == 2'd1);

  p_br2_target_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_valid && !out_illegal && out_class == 3'd2 |->
      out_has_target && out_len == (out_b_imm ? 2'd3 : 2'd2));

  p_br1_short_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_valid && !out_illegal && out_class == 3'd3 |-> !out_has_target && out_len != 2'd3);

endmodule

bind wordcode_decoder wcd_checker #(.WORD_W(WORD_W)) u_wcd_checker (
  .clk            (clk),
  .rst_core_n     (rst_core_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_class      (out_class),
  .out_opcode     (out_opcode),
  .out_a          (out_a),
  .out_b          (out_b),
  .out_b_imm      (out_b_imm),
  .out_target     (out_target),
  .out_has_target (out_has_target),
  .out_len        (out_len),
  .out_illegal    (out_illegal)
);

// File: tb/test_wordcode_decoder.sv
`timescale 1ns/1ps
module test_wordcode_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_word;
  logic        out_valid;
  logic        out_ready;
  logic [2:0]  out_class;
  logic [7:0]  out_opcode;
  logic [15:0] out_a, out_b, out_target;
  logic        out_a_imm, out_b_imm, out_has_target, out_illegal;
  logic [5:0]  out_port;
  logic [1:0]  out_len;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  wordcode_decoder #(.WORD_W(16)) i_wordcode_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_class(out_class), .out_opcode(out_opcode), .out_a(out_a),
    .out_a_imm(out_a_imm), .out_b(out_b), .out_b_imm(out_b_imm),
    .out_target(out_target), .out_has_target(out_has_target),
    .out_port(out_port), .out_len(out_len), .out_illegal(out_illegal)
  );

  // expected record
  logic [2:0]  e_cls;
  logic [7:0]  e_op;
  logic [15:0] e_a, e_b, e_t;
  logic        e_ai, e_bi, e_ht, e_ill;
  logic [5:0]  e_port;
  int          e_len;
  string       e_tag;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit op_ok(input logic [7:0] op);
    if (op < 8'h20 || op >= 8'h70) return 0;
    if (op inside {[8'h26:8'h27], [8'h2E:8'h2F], [8'h33:8'h37], [8'h3B:8'h3F],
                   [8'h5D:8'h5F], [8'h66:8'h67], [8'h6E:8'h6F]}) return 0;
    return 1;
  endfunction

  task automatic model(input logic [15:0] w, input logic [15:0] i0, input logic [15:0] i1);
    logic [7:0] op;
    e_cls = 0; e_op = 0; e_a = 0; e_b = 0; e_t = 0;
    e_ai = 0; e_bi = 0; e_ht = 0; e_ill = 0; e_port = 0; e_len = 1;
    if (w >= 16'h2000) begin
      op = w[15:8];
      if (!op_ok(op)) begin e_ill = 1; e_tag = (op >= 8'h80) ? "R9" : "R10"; end
      else begin
        e_op = op; e_a = 16'(w[7:4]); e_b = 16'(w[3:0]);
        if (op < 8'h30) begin e_cls = 2; e_ht = 1; e_t = i0; e_len = 2; e_tag = "R7"; end
        else if (op < 8'h40) begin e_cls = 3; e_tag = "R8"; end
        else begin e_cls = 4; e_tag = "R2"; end
      end
    end else if (w >= 16'h1000) begin
      if (w[11]) begin e_ill = 1; e_tag = "R9"; end
      else if (w[10] == 0) begin e_cls = 1; e_op = 8'h10; e_a = 16'(w[7:4]); e_port = {w[9:8], w[3:0]}; e_tag = "R6"; end
      else begin e_cls = 1; e_op = 8'h14; e_b = 16'(w[3:0]); e_port = {w[9:8], w[7:4]}; e_tag = "R6"; end
    end else if (w >= 16'h0200) begin
      op = w[11:4];
      if (!op_ok(op)) begin e_ill = 1; e_tag = (op >= 8'h80) ? "R9" : "R10"; end
      else begin
        e_op = op; e_a = 16'(w[3:0]); e_b = i0; e_bi = 1; e_len = 2; e_tag = "R3";
        if (op < 8'h30) begin e_cls = 2; e_ht = 1; e_t = i1; e_len = 3; e_tag = "R7"; end
        else if (op < 8'h40) e_cls = 3;
        else e_cls = 4;
      end
    end else if (w >= 16'h0100) begin
      if (w >= 16'h0140 && w < 16'h0180) begin
        e_cls = 1; e_op = 8'h14; e_port = w[5:0]; e_b = i0; e_bi = 1; e_len = 2; e_tag = "R6";
      end else begin e_ill = 1; e_tag = "R9"; end
    end else if (w <= 16'h0008) begin
      e_op = w[7:0]; e_tag = "R4";
      if (w >= 1 && w <= 3) begin e_a = i0; e_ai = 1; e_len = 2; end
      if (w == 4 || w == 5) begin e_a = i0; e_ai = 1; e_b = i1; e_bi = 1; e_len = 3; end
    end else if (w >= 16'h0010 && w < 16'h0070) begin
      e_op = {w[7:4], 4'h0}; e_tag = "R5";
      if (w[7:4] == 4 || w[7:4] == 5) begin e_a = i0; e_ai = 1; e_b = 16'(w[3:0]); e_len = 2; end
      else e_a = 16'(w[3:0]);
    end else begin
      e_ill = 1; e_tag = "R9";
    end
  endtask

  task automatic put_word(input logic [15:0] x);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = x;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic check_record();
    check(e_tag, "valid", 32'(out_valid), 32'd1);
    check(e_tag, "illegal", 32'(out_illegal), 32'(e_ill));
    check(e_tag, "class", 32'(out_class), 32'(e_cls));
    check(e_tag, "opcode", 32'(out_opcode), 32'(e_op));
    check(e_tag, "a", 32'(out_a), 32'(e_a));
    check(e_tag, "a_imm", 32'(out_a_imm), 32'(e_ai));
    check(e_tag, "b", 32'(out_b), 32'(e_b));
    check(e_tag, "b_imm", 32'(out_b_imm), 32'(e_bi));
    check(e_tag, "target", 32'(out_target), 32'(e_t));
    check(e_tag, "has_target", 32'(out_has_target), 32'(e_ht));
    check(e_tag, "port", 32'(out_port), 32'(e_port));
    check("R12", "len", 32'(out_len), 32'(e_len));
  endtask

  task automatic run_insn(input logic [15:0] w);
    logic [15:0] i0, i1;
    i0 = 16'hC000 ^ w;
    i1 = 16'h3000 ^ {w[7:0], w[15:8]};
    model(w, i0, i1);
    put_word(w);
    if (e_len >= 2) put_word(i0);
    if (e_len >= 3) put_word(i1);
    @(negedge clk);
    check_record();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "out_valid after reset", 32'(out_valid), 32'd0);
    check("R1", "in_ready after reset", 32'(in_ready), 32'd1);

    // exhaustive sweep of the low 8192 words (specials, I/O, immediate forms)
    for (int w = 0; w < 16'h2000; w++) run_insn(16'(w));
    // every top byte of the register form, two low-byte patterns
    for (int t = 16'h20; t < 16'h100; t++) begin
      run_insn({8'(t), 8'(t * 7 + 3)});
      run_insn({8'(t), 8'(t ^ 8'hA5)});
    end

    // R9: illegal word followed directly by a legal one, no idle gap
    model(16'h0009, 16'h0, 16'h0);
    put_word(16'h0009);
    @(negedge clk);
    check("R9", "illegal flag", 32'(out_illegal), 32'd1);
    run_insn(16'h4E21);

    // R7: trailing words with idle gaps between them
    put_word(16'h0204);
    repeat (2) begin
      @(negedge clk);
      check("R7", "no early record", 32'(out_valid), 32'd0);
    end
    put_word(16'h1111);
    @(negedge clk);
    check("R7", "no early record", 32'(out_valid), 32'd0);
    put_word(16'h2222);
    @(negedge clk);
    check("R7", "b after gaps", 32'(out_b), 32'h1111);
    check("R7", "target after gaps", 32'(out_target), 32'h2222);
    check("R12", "len after gaps", 32'(out_len), 32'd3);

    // R11 / R12: stall, then accept and take next word at the same edge
    @(negedge clk);
    out_ready = 1'b0;
    put_word(16'h4E12);
    @(negedge clk);
    check("R11", "held valid", 32'(out_valid), 32'd1);
    in_valid = 1'b1;
    in_word  = 16'h4F34;
    for (int k = 0; k < 3; k++) begin
      check("R11", "in_ready low in stall", 32'(in_ready), 32'd0);
      check("R11", "opcode held", 32'(out_opcode), 32'h4E);
      check("R11", "b held", 32'(out_b), 32'h2);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check("R12", "next record valid", 32'(out_valid), 32'd1);
    check("R12", "next record opcode", 32'(out_opcode), 32'h4F);
    check("R12", "next record a", 32'(out_a), 32'h3);
    check("R12", "next record b", 32'(out_b), 32'h4);
    @(negedge clk);
    check("R12", "record consumed", 32'(out_valid), 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule